// File: doc/BRIEF.md
# SPI Master With Access-Triggered Transfers

This block is a single-master SPI peripheral that sits on a simple 16-bit register bus. Software sets it up through control, chip-select, baud and status registers. It then moves words through a transmit buffer and a receive buffer. A new word is never started by a separate command. It starts as a side effect of a bus access, and a two-bit field in the control register picks which access does it:

- In the read-triggered modes, a read of the receive buffer launches the next word. The word shifted out is whatever the transmit buffer holds at that moment.
- In the write-triggered modes, each write to the transmit buffer launches a word. If the shifter is still busy, the word is queued until the shifter is free.

A shadow location returns the last received word without starting anything. This lets software collect the final word of a read burst without causing one more shift. The serial clock is derived from the system clock by a programmable divider. Words are 8 or 16 bits, sent most- or least-significant bit first, in any of the four clock polarity and phase combinations. Seven active-low select lines are each either released or driven to a programmed level. Two of the four trigger encodings also raise a one-cycle DMA request, so that an external engine can pace the transfers.

Top module: `spim_top`

## Requirements
- R1: After reset, status reads 0, every select line is high, `sck` is low, `mosi` is high and `dmaReq` is low.
- R2: One `sck` half period lasts `max(baud,2)` system clocks, where baud is the register at byte offset 0x14. Between words, `sck` rests at the polarity bit (control bit 11).
- R3: Control bit 14 enables the block. Control bits [1:0] pick the trigger: 0 = receive-buffer read, 1 = transmit-buffer write, 2 = receive-buffer read plus DMA, 3 = transmit-buffer write plus DMA. In a write-triggered mode, a write to offset 0x0C sends that word. Control bit 9 set means LSB first; clear means MSB first.
- R4: In a read-triggered mode, a read of offset 0x10 starts a word that shifts out the current transmit buffer, and a transmit-buffer write alone starts nothing. A read of the shadow at 0x18 returns the received word and starts nothing.
- R5: Control bit 10 clear means the receive data is sampled on the leading `sck` edge. Set means it is sampled on the trailing edge.
- R6: The status register is at offset 0x08. Bit 0 (finished) sets when a word completes. Bit 3 (transmit full) sets on a transmit-buffer write and clears when that word enters the shifter. Bit 4 (receive full) sets when a word lands; a receive-buffer read clears it and a shadow read does not. Bit 5 reads as 1 while a word is shifting.
- R7: Writing 1 to status bits 0, 1 or 2 clears those bits. Writing 0 leaves them unchanged.
- R8: Status bit 1 (overflow) sets when a word lands while receive full is still set. Status bit 2 (collision) sets when the transmit buffer is written while transmit full is still set.
- R9: The flag register is at offset 0x04 and resets to 0xFF00. Select line k (k = 0..6) is driven to flag bit k+9 when flag bit k+1 is set, and is high otherwise. Writing 0xFF00 releases every line.
- R10: In mode 3, `dmaReq` pulses for one cycle each time a word enters the shifter. In mode 2, it pulses for one cycle each time a received word lands.
- R11: Control bit 8 set gives 16-bit words. Clear gives 8-bit words.
- R12: While control bit 14 is clear, no word starts and `sck` stays at rest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busEn | input | 1 | Bus access strobe, one cycle per access |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | 5 | Byte offset of the register |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data, valid in the access cycle |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out, high when idle |
| miso | input | 1 | Serial data in |
| csN | output | 7 | Active-low select lines |
| dmaReq | output | 1 | One-cycle DMA request pulse |

## Verification
A wrong shifter index or a misplaced sampling edge shows up at the end of the first word: the bits captured on `mosi` are permuted, or the shadow returns the slave's word shifted by one bit. A divider or edge-count error moves the spacing of `sck` edges from the very first edge, and it shows in the status busy bit when the word ends early or late. Errors in the trigger decode or the status flags are caught on the next status read: a spurious busy bit, a stuck full flag, or an overflow or collision bit that should or should not be there. The select lines are compared with a model of the flag register on every clock, so a decode error there is caught within one cycle of the write.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int REG_W = 16;

  // word index of each register (byte offset / 4)
  localparam logic [2:0] ADR_CTRL   = 3'd0;
  localparam logic [2:0] ADR_FLAG   = 3'd1;
  localparam logic [2:0] ADR_STAT   = 3'd2;
  localparam logic [2:0] ADR_TX     = 3'd3;
  localparam logic [2:0] ADR_RX     = 3'd4;
  localparam logic [2:0] ADR_BAUD   = 3'd5;
  localparam logic [2:0] ADR_SHADOW = 3'd6;

  // control bit positions
  localparam int B_EN   = 14;
  localparam int B_CPOL = 11;
  localparam int B_CPHA = 10;
  localparam int B_LSB  = 9;
  localparam int B_WIDE = 8;

  typedef enum logic [1:0] {
    INIT_RD     = 2'd0,
    INIT_WR     = 2'd1,
    INIT_DMA_RX = 2'd2,
    INIT_DMA_TX = 2'd3
  } initMode_e;

  typedef struct packed {
    logic             enable;
    logic             wide;
    logic             cpol;
    logic             cpha;
    logic [REG_W-1:0] baud;
    logic             startReady;
  } cfg_t;

  typedef struct packed {
    logic       busy;
    logic       load;
    logic       sample;
    logic       done;
    logic [3:0] driveIdx;
    logic [3:0] sampIdx;
  } strobe_t;
endpackage

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  cfg_t    cfg,
  output strobe_t strb,
  output logic    sck
);
  logic             busyQ, sckQ, tick;
  logic [REG_W-1:0] divCnt, halfDiv;
  logic [5:0]       edgeCnt, lastEdge;

  always_comb begin
    halfDiv       = (cfg.baud < REG_W'(2)) ? REG_W'(2) : cfg.baud;
    lastEdge      = cfg.wide ? 6'd31 : 6'd15;
    tick          = busyQ && (divCnt >= halfDiv - 1'b1);
    strb.busy     = busyQ;
    strb.load     = cfg.enable && !busyQ && cfg.startReady;
    strb.sample   = tick && (edgeCnt[0] == cfg.cpha);
    strb.done     = tick && (edgeCnt == lastEdge);
    strb.sampIdx  = edgeCnt[4:1];
    if (cfg.cpha)
      strb.driveIdx = (edgeCnt == 6'd0) ? 4'd0 : 4'((edgeCnt - 6'd1) >> 1);
    else
      strb.driveIdx = edgeCnt[4:1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ   <= 1'b0;
      sckQ    <= 1'b0;
      divCnt  <= '0;
      edgeCnt <= '0;
    end else if (!cfg.enable) begin
      busyQ <= 1'b0;
    end else if (strb.load) begin
      busyQ   <= 1'b1;
      divCnt  <= '0;
      edgeCnt <= '0;
      sckQ    <= cfg.cpol;
    end else if (busyQ) begin
      if (tick) begin
        divCnt  <= '0;
        sckQ    <= ~sckQ;
        edgeCnt <= edgeCnt + 6'd1;
        if (strb.done) busyQ <= 1'b0;
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  assign sck = busyQ ? sckQ : cfg.cpol;
endmodule

// File: rtl/spim_dpath.sv
module spim_dpath
  import spim_pkg::*;
#(
  parameter int NUM_CS = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busEn,
  input  logic              busWe,
  input  logic [4:0]        busAddr,
  input  logic [REG_W-1:0]  busWdata,
  output logic [REG_W-1:0]  busRdata,
  input  logic              miso,
  input  strobe_t           strb,
  output cfg_t              cfg,
  output logic              mosi,
  output logic [NUM_CS-1:0] csN,
  output logic              dmaReq,
  output logic              txFullMon,
  output logic              rxFullMon
);
  logic [REG_W-1:0] ctrlQ, flagQ, baudQ, txBufQ, rxBufQ, txShQ, rxShQ, rxNext;
  logic finQ, ovfQ, colQ, txFullQ, rxFullQ, rdPendQ, dmaQ;
  logic hit, rdEn, wrEn, wrTx, rdRx;
  logic [2:0] sel;
  logic [3:0] sampBit, driveBit;
  initMode_e mode;

  function automatic logic [3:0] physBit(input logic [3:0] k, input logic lsb, input logic wide);
    if (lsb) return k;
    else if (wide) return 4'd15 - k;
    else return 4'd7 - k;
  endfunction

  always_comb begin
    hit      = busEn && (busAddr[1:0] == 2'b00);
    sel      = busAddr[4:2];
    rdEn     = hit && !busWe;
    wrEn     = hit && busWe;
    wrTx     = wrEn && (sel == ADR_TX);
    rdRx     = rdEn && (sel == ADR_RX);
    mode     = initMode_e'(ctrlQ[1:0]);
    sampBit  = physBit(strb.sampIdx, ctrlQ[B_LSB], ctrlQ[B_WIDE]);
    driveBit = physBit(strb.driveIdx, ctrlQ[B_LSB], ctrlQ[B_WIDE]);
    rxNext   = rxShQ;
    if (strb.sample) rxNext[sampBit] = miso;

    cfg.enable     = ctrlQ[B_EN];
    cfg.wide       = ctrlQ[B_WIDE];
    cfg.cpol       = ctrlQ[B_CPOL];
    cfg.cpha       = ctrlQ[B_CPHA];
    cfg.baud       = baudQ;
    cfg.startReady = mode[0] ? txFullQ : rdPendQ;

    mosi = strb.busy ? txShQ[driveBit] : 1'b1;

    case (sel)
      ADR_CTRL:            busRdata = ctrlQ;
      ADR_FLAG:            busRdata = flagQ;
      ADR_STAT:            busRdata = {10'd0, strb.busy, rxFullQ, txFullQ, colQ, ovfQ, finQ};
      ADR_TX:              busRdata = txBufQ;
      ADR_RX, ADR_SHADOW:  busRdata = rxBufQ;
      ADR_BAUD:            busRdata = baudQ;
      default:             busRdata = '0;
    endcase
  end

  for (genvar k = 0; k < NUM_CS; k++) begin : g_cs
    assign csN[k] = flagQ[k+1] ? flagQ[k+9] : 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0; flagQ <= 16'hFF00; baudQ <= '0; txBufQ <= '0;
      rxBufQ <= '0; txShQ <= '0; rxShQ <= '0;
      finQ <= 1'b0; ovfQ <= 1'b0; colQ <= 1'b0;
      txFullQ <= 1'b0; rxFullQ <= 1'b0; rdPendQ <= 1'b0; dmaQ <= 1'b0;
    end else begin
      dmaQ <= ((mode == INIT_DMA_RX) && strb.done) || ((mode == INIT_DMA_TX) && strb.load);
      if (wrEn) begin
        case (sel)
          ADR_CTRL: ctrlQ  <= busWdata;
          ADR_FLAG: flagQ  <= busWdata;
          ADR_BAUD: baudQ  <= busWdata;
          ADR_TX:   txBufQ <= busWdata;
          default: ;
        endcase
      end
      if (strb.sample) rxShQ <= rxNext;
      if (strb.load) begin
        txShQ   <= txBufQ;
        rxShQ   <= '0;
        txFullQ <= 1'b0;
        rdPendQ <= 1'b0;
        finQ    <= 1'b0;
      end
      if (wrTx) begin
        txFullQ <= 1'b1;
        if (txFullQ && !strb.load) colQ <= 1'b1;
      end
      if (rdRx && !mode[0]) rdPendQ <= 1'b1;
      if (rdRx) rxFullQ <= 1'b0;
      if (wrEn && (sel == ADR_STAT)) begin
        if (busWdata[0]) finQ <= 1'b0;
        if (busWdata[1]) ovfQ <= 1'b0;
        if (busWdata[2]) colQ <= 1'b0;
      end
      if (strb.done) begin
        rxBufQ  <= rxNext;
        rxFullQ <= 1'b1;
        finQ    <= 1'b1;
        if (rxFullQ && !rdRx) ovfQ <= 1'b1;
      end
    end
  end

  assign dmaReq    = dmaQ;
  assign txFullMon = txFullQ;
  assign rxFullMon = rxFullQ;
endmodule

// File: rtl/spim_top.sv
module spim_top
  import spim_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busEn,
  input  logic        busWe,
  input  logic [4:0]  busAddr,
  input  logic [15:0] busWdata,
  output logic [15:0] busRdata,
  output logic        sck,
  output logic        mosi,
  input  logic        miso,
  output logic [6:0]  csN,
  output logic        dmaReq
);
  cfg_t    cfg;
  strobe_t strb;
  logic    txFullMon, rxFullMon;

  spim_ctrl u_ctrl (
    .clk (clk), .rstN (rstN), .cfg (cfg), .strb (strb), .sck (sck)
  );

  spim_dpath #(.NUM_CS(7)) u_dpath (
    .clk (clk), .rstN (rstN), .busEn (busEn), .busWe (busWe), .busAddr (busAddr),
    .busWdata (busWdata), .busRdata (busRdata), .miso (miso), .strb (strb),
    .cfg (cfg), .mosi (mosi), .csN (csN), .dmaReq (dmaReq),
    .txFullMon (txFullMon), .rxFullMon (rxFullMon)
  );
endmodule

// File: rtl/spim_checker.sv
module spim_checker
  import spim_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        busEn,
  input logic        busWe,
  input logic [4:0]  busAddr,
  input logic [15:0] busWdata,
  input logic        sck,
  input logic [6:0]  csN,
  input logic        dmaReq,
  input cfg_t        cfg,
  input strobe_t     strb,
  input logic        txFullMon,
  input logic        rxFullMon
);
  logic txWrite, flagRelease;
  assign txWrite     = busEn && busWe && (busAddr == 5'h0C);
  assign flagRelease = busEn && busWe && (busAddr == 5'h04) && (busWdata == 16'hFF00);

  // R10: a request is a single-cycle pulse
  a_r10_dma_single: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq |=> !dmaReq);

  // R2: the clock does not move between words
  a_r2_sck_quiet_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.busy && !$past(strb.busy) && ($past(cfg.cpol) == cfg.cpol)) |-> $stable(sck));

  // R6: transmit full drops once the word enters the shifter
  a_r6_txfull_cleared: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && !txWrite) |=> !txFullMon);

  // R6: a completed word marks the receive buffer full
  a_r6_rxfull_on_done: assert property (@(posedge clk) disable iff (!rstN)
    strb.done |=> rxFullMon);

  // R12: disabling stops the shifter
  a_r12_idle_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.enable |=> !strb.busy);

  // R9: releasing the flag register raises every select
  a_r9_cs_release: assert property (@(posedge clk) disable iff (!rstN)
    flagRelease |=> (&csN));
endmodule

bind spim_top spim_checker u_chk (
  .clk (clk), .rstN (rstN), .busEn (busEn), .busWe (busWe), .busAddr (busAddr),
  .busWdata (busWdata), .sck (sck), .csN (csN), .dmaReq (dmaReq),
  .cfg (cfg), .strb (strb), .txFullMon (txFullMon), .rxFullMon (rxFullMon)
);

// File: tb/spim_top_tb.sv
module spim_top_tb;
  logic clk = 1'b0, rstN = 1'b0;
  logic busEn = 1'b0, busWe = 1'b0;
  logic [4:0] busAddr = '0;
  logic [15:0] busWdata = '0, busRdata;
  logic sck, mosi, miso = 1'b0, dmaReq;
  logic [6:0] csN;

  int tests = 0, fails = 0;
  // behavioural model state
  logic [15:0] flagModel = 16'hFF00;
  logic [15:0] slaveWord = '0, capWord = '0;
  logic bCpha = 0, bLsb = 0, bWide = 0;
  int edgeN = 0, cyc = 0, lastEdgeCyc = 0, halfMeas = 0, dmaCnt = 0;
  logic prevSck = 0, prevMosi = 1;
  logic [15:0] st, rv;

  spim_top u_dut (.clk(clk), .rstN(rstN), .busEn(busEn), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .sck(sck), .mosi(mosi), .miso(miso),
    .csN(csN), .dmaReq(dmaReq));

  always #10 clk = ~clk;

  function automatic int phys(input int k, input logic lsb, input logic wide);
    if (lsb) return k;
    return wide ? 15 - k : 7 - k;
  endfunction

  function automatic logic [6:0] csExp(input logic [15:0] f);
    logic [6:0] r;
    for (int k = 0; k < 7; k++) r[k] = f[k+1] ? f[k+9] : 1'b1;
    return r;
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // slave model and per-clock comparison
  always @(negedge clk) begin
    cyc++;
    if (dmaReq) dmaCnt++;
    if (rstN) check(csN == csExp(flagModel), "R9 csN", {25'd0, csN}, {25'd0, csExp(flagModel)});
    if (sck !== prevSck) begin
      int nb;
      nb = bWide ? 16 : 8;
      if ((edgeN % 2 == (bCpha ? 1 : 0)) && (edgeN / 2 < nb))
        capWord[phys(edgeN / 2, bLsb, bWide)] = prevMosi;
      edgeN++;
      halfMeas = cyc - lastEdgeCyc;
      lastEdgeCyc = cyc;
    end
    begin
      int idx;
      idx = bCpha ? ((edgeN == 0) ? 0 : (edgeN - 1) / 2) : edgeN / 2;
      if (idx < (bWide ? 16 : 8)) miso = slaveWord[phys(idx, bLsb, bWide)];
    end
    prevSck = sck;
    prevMosi = mosi;
  end

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    busEn = 1; busWe = 1; busAddr = a; busWdata = d;
    @(posedge clk);
    #1 if (a == 5'h04) flagModel = d;
    @(negedge clk);
    busEn = 0; busWe = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    busEn = 1; busWe = 0; busAddr = a;
    #1 d = busRdata;
    @(negedge clk);
    busEn = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic arm(input logic [15:0] sw, input logic cp, input logic lsb, input logic wide);
    @(negedge clk);
    #2 edgeN = 0; capWord = '0; slaveWord = sw; bCpha = cp; bLsb = lsb; bWide = wide;
  endtask

  task automatic waitDone;
    logic [15:0] s;
    for (int i = 0; i < 3000; i++) begin
      rd(5'h08, s);
      if (s[0] && !s[5]) return;
    end
    check(0, "R6 finished never set", {16'd0, s}, 32'h1);
  endtask

  initial begin
    #(20 * 150000);
    check(0, "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    idle(3);
    rstN = 1;
    idle(2);
    // R1 reset state
    rd(5'h08, st);
    check(st == 0, "R1 status", st, 0);
    check(csN == 7'h7F && sck == 0 && mosi == 1 && dmaReq == 0, "R1 pins",
          {csN, sck, mosi, dmaReq}, {7'h7F, 3'b010});

    // R9 select cs0 low, R3 write-initiate 8-bit MSB first
    wr(5'h04, 16'hFD02);
    idle(1);
    check(csN == 7'b1111110, "R9 cs0 low", csN, 7'b1111110);
    wr(5'h14, 16'd0);
    wr(5'h00, 16'h5001);
    arm(16'h003C, 0, 0, 0);
    wr(5'h0C, 16'h00A5);
    waitDone;
    check(capWord[7:0] == 8'hA5, "R3 msb-first word", capWord, 8'hA5);
    check(halfMeas == 2, "R2 half period baud0", halfMeas, 2);
    rd(5'h18, rv);
    check(rv == 16'h003C, "R4 shadow data", rv, 16'h3C);
    rd(5'h08, st);
    check((st & 16'h0039) == 16'h0011, "R6 finished+rxfull", st, 16'h11);
    idle(10);
    rd(5'h08, st);
    check(st == 16'h0011, "R4 shadow read starts nothing", st, 16'h11);

    // R8 overflow
    arm(16'h0055, 0, 0, 0);
    wr(5'h0C, 16'h000F);
    waitDone;
    check(capWord[7:0] == 8'h0F, "R3 second word", capWord, 8'h0F);
    rd(5'h08, st);
    check(st[1] == 1, "R8 overflow", st, 16'h13);
    rd(5'h10, rv);
    check(rv == 16'h0055, "R3 rx data", rv, 16'h55);
    rd(5'h08, st);
    check(st == 16'h0003, "R6 rx read clears full", st, 16'h3);
    // R7 write-one-to-clear
    wr(5'h08, 16'h0002);
    rd(5'h08, st);
    check(st == 16'h0001, "R7 clear ovf only", st, 16'h1);
    wr(5'h08, 16'h0007);
    rd(5'h08, st);
    check(st == 16'h0000, "R7 clear all", st, 0);

    // R8 collision
    wr(5'h14, 16'd8);
    arm(16'h0000, 0, 0, 0);
    wr(5'h0C, 16'h0011);
    wr(5'h0C, 16'h0022);
    wr(5'h0C, 16'h0033);
    rd(5'h08, st);
    check(st[2] == 1 && st[3] == 1, "R8 collision", st, 16'h2C);
    idle(700);
    rd(5'h08, st);
    check(st[5] == 0 && st[3] == 0, "R8 queued word drained", st, 16'h17);
    wr(5'h08, 16'h0007);
    rd(5'h10, rv);

    // R5 R11 R2: 16-bit, LSB first, cpha1 cpol1, baud 3
    wr(5'h14, 16'd3);
    wr(5'h00, 16'h5F01);
    idle(2);
    check(sck == 1, "R2 idle level cpol1", sck, 1);
    arm(16'hBEEF, 1, 1, 1);
    wr(5'h0C, 16'h1234);
    waitDone;
    check(capWord == 16'h1234, "R11 R5 16-bit lsb word", capWord, 16'h1234);
    check(halfMeas == 3, "R2 half period baud3", halfMeas, 3);
    rd(5'h18, rv);
    check(rv == 16'hBEEF, "R5 trailing-edge sample", rv, 16'hBEEF);

    // R11 16-bit MSB first cpha0
    wr(5'h14, 16'd2);
    wr(5'h00, 16'h5101);
    arm(16'h5A0F, 0, 0, 1);
    wr(5'h0C, 16'hC3A5);
    waitDone;
    check(capWord == 16'hC3A5, "R11 16-bit msb word", capWord, 16'hC3A5);
    rd(5'h18, rv);
    check(rv == 16'h5A0F, "R11 rx 16-bit", rv, 16'h5A0F);

    // R4 read-initiate
    wr(5'h00, 16'h5400);
    wr(5'h08, 16'h0007);
    wr(5'h0C, 16'h0096);
    idle(30);
    rd(5'h08, st);
    check(st[5] == 0 && st[3] == 1 && st[0] == 0, "R4 tx write alone starts nothing", st, 16'h18);
    arm(16'h0069, 1, 0, 0);
    rd(5'h10, rv);
    waitDone;
    check(capWord[7:0] == 8'h96, "R4 read shifts tx buffer", capWord, 8'h96);
    rd(5'h18, rv);
    check(rv == 16'h0069, "R4 read-initiate rx", rv, 16'h69);

    // R10 DMA modes
    wr(5'h00, 16'h5003);
    arm(16'h0000, 0, 0, 0);
    dmaCnt = 0;
    wr(5'h0C, 16'h0042);
    waitDone;
    check(dmaCnt == 1, "R10 dma on tx move", dmaCnt, 1);
    wr(5'h00, 16'h5002);
    arm(16'h0000, 0, 0, 0);
    dmaCnt = 0;
    rd(5'h10, rv);
    waitDone;
    idle(3);
    check(dmaCnt == 1, "R10 dma on rx land", dmaCnt, 1);

    // R12 disabled
    wr(5'h00, 16'h1001);
    arm(16'h0000, 0, 0, 0);
    wr(5'h0C, 16'h0077);
    idle(50);
    rd(5'h08, st);
    check(st[5] == 0 && st[3] == 1, "R12 no start when off", st, 16'h08);
    check(edgeN == 0, "R12 sck still", edgeN, 0);

    // R9 release and level
    wr(5'h04, 16'hFF08);
    idle(1);
    check(csN == 7'h7F, "R9 enabled high level", csN, 7'h7F);
    wr(5'h04, 16'hF708);
    idle(1);
    check(csN == 7'b1111011, "R9 cs2 low", csN, 7'b1111011);
    wr(5'h04, 16'hFF00);
    idle(1);
    check(csN == 7'h7F, "R9 release all", csN, 7'h7F);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule